// File: doc/BRIEF.md
# Device Interrupt Routing Controller

This block sits between a set of device interrupt lines and the processors of a chip. For every interrupt source it keeps a routing entry, which holds a target CPU number and an interrupt vector. It also keeps a control entry, which holds a mask bit and a pending flag. When a source that is not masked pulses its line, the block accepts the interrupt. Accepting it sets both the mask and the pending flag, so each source fires only once until software re-arms it. The block then issues a single-cycle post carrying the stored CPU and vector.

Software reaches the entries through a simple register port with 64-bit data words. Each source owns one 8-byte word in the routing region and one in the control region. Software writes the routing words to program targets. It reads and writes the control words to inspect a source, unmask it, or clear its pending flag. Several sources may be accepted in the same cycle. Accepted sources wait in an internal set of flags and drain onto the post output one per cycle, lowest source number first.

Top module: `irq_route_ctrl`

## Requirements
- R1: A write to a routing word stores the target CPU from data bits [12:8] and the vector from data bits [5:0]. A read of that word returns the same layout, with every other bit zero.
- R2: A read of a control word returns the mask in bit 2 and the pending flag in bit 0, with every other bit zero.
- R3: A control write loads the mask from data bit 2. If data bit 1 is 1, the write clears the pending flag. No write can set the pending flag, whatever is in bit 0.
- R4: After reset every source is masked and not pending, every routing entry is zero, and no post is issued.
- R5: An interrupt pulse on a masked source has no effect: no post follows and the control word is unchanged.
- R6: An interrupt pulse on an unmasked source is accepted and sets both that source's mask and its pending flag.
- R7: An accepted interrupt produces exactly one post: post_valid_o is high for one cycle after the second rising edge from the edge that sampled the pulse. The post carries the CPU and vector held in the routing entry when the post is issued. post_cpu_o and post_vec_o are zero whenever post_valid_o is low.
- R8: At most one post is issued per cycle. When several accepted sources are waiting, the lowest-numbered one posts first and the others follow in later cycles.
- R9: If an accepted interrupt and a control write to the same source fall in the same cycle, the interrupt wins: mask and pending both end at 1, and the post is still issued.
- R10: A request to an offset that decodes to no register raises err_o for one cycle. A read there returns zero. A write there changes no state.
- R11: The word index is the byte offset shifted right by 3, with offset bits [2:0] ignored. Routing words occupy indices 0 to NUM_SRC-1 and control words occupy indices NUM_SRC to 2*NUM_SRC-1.
- R12: Read data appears on rdata_o in the cycle after the request and is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the register window |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, valid in the cycle after a read |
| err_o | output | 1 | One-cycle pulse after an access to an undecoded offset |
| irq_i | input | NUM_SRC | Device interrupt pulses, one bit per source |
| post_valid_o | output | 1 | Single-cycle interrupt post strobe |
| post_cpu_o | output | 5 | Target CPU of the post |
| post_vec_o | output | 6 | Vector of the post |

## Verification
Two functions can act on the same source in the same cycle: accepting a device pulse, and a software control write that unmasks the source or clears its pending flag. The bench provokes this on purpose. It drives a pulse on an unmasked source in the same cycle as a control write that clears the source's pending flag. It then checks that both mask and pending read back as 1 and that the post still appears. A long random phase mixes sparse pulses with register traffic that keeps re-arming sources. A behavioural model predicts every post, every read word and every error pulse from the requirements, and the bench compares them with the design each cycle. The model also drains simultaneous acceptances in order of source number.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int DATA_W   = 64;
  localparam int CPU_W    = 5;
  localparam int VEC_W    = 6;
  localparam int CPU_LSB  = 8;
  localparam int MASK_BIT = 2;
  localparam int CLR_BIT  = 1;
  localparam int PEND_BIT = 0;

  typedef struct packed {
    logic [CPU_W-1:0] cpu;
    logic [VEC_W-1:0] vec;
  } route_t;

  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_ROUTE = 2'd1,
    RGN_CTL   = 2'd2
  } region_e;
endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12,
  localparam int WORD_W = ADDR_W - 3
) (
  input  logic [WORD_W-1:0] word_i,
  output region_e           region_o,
  output logic [WORD_W-1:0] idx_o
);
  localparam logic [WORD_W:0] ROUTE_END = (WORD_W+1)'(NUM_SRC);
  localparam logic [WORD_W:0] CTL_END   = (WORD_W+1)'(2 * NUM_SRC);

  always_comb begin
    region_o = RGN_NONE;
    idx_o    = '0;
    if ({1'b0, word_i} < ROUTE_END) begin
      region_o = RGN_ROUTE;
      idx_o    = word_i;
    end else if ({1'b0, word_i} < CTL_END) begin
      region_o = RGN_CTL;
      idx_o    = word_i - WORD_W'(NUM_SRC);
    end
  end
endmodule

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_route_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   irq_i,
  input  logic   route_wr_i,
  input  route_t route_d_i,
  input  logic   ctl_wr_i,
  input  logic   mask_d_i,
  input  logic   pend_clr_i,
  output route_t route_o,
  output logic   mask_o,
  output logic   pend_o,
  output logic   accept_o
);
  route_t route_q;
  logic   mask_q, pend_q;

  assign accept_o = irq_i & ~mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_q <= '0;
      mask_q  <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      if (route_wr_i) route_q <= route_d_i;
      // an accepted pulse overrides a concurrent control write
      if (accept_o)      mask_q <= 1'b1;
      else if (ctl_wr_i) mask_q <= mask_d_i;
      if (accept_o)                   pend_q <= 1'b1;
      else if (ctl_wr_i & pend_clr_i) pend_q <= 1'b0;
    end
  end

  assign route_o = route_q;
  assign mask_o  = mask_q;
  assign pend_o  = pend_q;

  a_r6_accept_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !mask_o) |=> (mask_o && pend_o));
  a_r5_masked_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && mask_o && !ctl_wr_i) |=> (mask_o && pend_o == $past(pend_o)));
  a_r3_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_o && !(irq_i && !mask_o)) |=> !pend_o);
  a_r9_hw_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !mask_o && ctl_wr_i) |=> (mask_o && pend_o));
endmodule

// File: rtl/irq_post_arb.sv
module irq_post_arb
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   accept_i,
  input  route_t [NUM_SRC-1:0] route_i,
  output logic                 post_valid_o,
  output route_t               post_route_o
);
  logic [NUM_SRC-1:0] wait_q, grant;
  route_t             sel;

  assign grant = wait_q & (~wait_q + NUM_SRC'(1));

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) sel = sel | route_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q       <= '0;
      post_valid_o <= 1'b0;
      post_route_o <= '0;
    end else begin
      wait_q       <= (wait_q & ~grant) | accept_i;
      post_valid_o <= |wait_q;
      post_route_o <= sel;
    end
  end

  a_r8_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q != '0) |=> post_valid_o);
  a_r8_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_q == '0) |=> !post_valid_o);
  a_r8_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant) <= 1);
  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !post_valid_o |-> (post_route_o == '0));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [63:0]        wdata_i,
  output logic [63:0]        rdata_o,
  output logic               err_o,
  input  logic [NUM_SRC-1:0] irq_i,
  output logic               post_valid_o,
  output logic [4:0]         post_cpu_o,
  output logic [5:0]         post_vec_o
);
  localparam int WORD_W = ADDR_W - 3;

  region_e              region;
  logic [WORD_W-1:0]    idx;
  route_t [NUM_SRC-1:0] route_q;
  logic [NUM_SRC-1:0]   mask_q, pend_q, accept;
  route_t               route_d, post_route;
  logic [DATA_W-1:0]    rd_d;
  logic                 unused_bits;

  assign unused_bits = ^{wdata_i, addr_i[2:0]};
  assign route_d     = '{cpu: wdata_i[CPU_LSB +: CPU_W], vec: wdata_i[VEC_W-1:0]};

  irq_addr_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
    .word_i  (addr_i[ADDR_W-1:3]),
    .region_o(region),
    .idx_o   (idx)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic hit;
    assign hit = req_i & we_i & (idx == WORD_W'(i));
    irq_src_slot u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .irq_i     (irq_i[i]),
      .route_wr_i(hit & (region == RGN_ROUTE)),
      .route_d_i (route_d),
      .ctl_wr_i  (hit & (region == RGN_CTL)),
      .mask_d_i  (wdata_i[MASK_BIT]),
      .pend_clr_i(wdata_i[CLR_BIT]),
      .route_o   (route_q[i]),
      .mask_o    (mask_q[i]),
      .pend_o    (pend_q[i]),
      .accept_o  (accept[i])
    );
  end

  irq_post_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .route_i     (route_q),
    .post_valid_o(post_valid_o),
    .post_route_o(post_route)
  );

  assign post_cpu_o = post_route.cpu;
  assign post_vec_o = post_route.vec;

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (idx == WORD_W'(i)) begin
        if (region == RGN_ROUTE) begin
          rd_d[CPU_LSB +: CPU_W] = route_q[i].cpu;
          rd_d[VEC_W-1:0]        = route_q[i].vec;
        end else if (region == RGN_CTL) begin
          rd_d[MASK_BIT] = mask_q[i];
          rd_d[PEND_BIT] = pend_q[i];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= (req_i & ~we_i) ? rd_d : '0;
      err_o   <= req_i & (region == RGN_NONE);
    end
  end

  a_r10_err_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));
  a_r12_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> (rdata_o == '0));
  a_r10_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !err_o);
endmodule

// File: tb/tb_irq_route_ctrl.sv
`timescale 1ns/1ps
module tb_irq_route_ctrl;
  localparam int N = 32;
  localparam int AW = 12;
  localparam int CTL = N * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [63:0]   wdata = '0;
  logic [63:0]   rdata;
  logic          err;
  logic [N-1:0]  irq = '0;
  logic          pv;
  logic [4:0]    pcpu;
  logic [5:0]    pvec;

  int checks = 0, errors = 0;
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  irq_route_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .irq_i(irq),
    .post_valid_o(pv), .post_cpu_o(pcpu), .post_vec_o(pvec)
  );

  // behavioural reference
  bit        m_mask[N], m_pend[N], m_wait[N];
  int        m_cpu[N], m_vec[N];
  bit        e_pv, e_err;
  int        e_cpu, e_vec;
  bit [63:0] e_rdata;

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_mask[i] = 1; m_pend[i] = 0; m_wait[i] = 0; m_cpu[i] = 0; m_vec[i] = 0;
    end
    e_pv = 0; e_err = 0; e_cpu = 0; e_vec = 0; e_rdata = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      bit acc[N];
      int w;
      int g;
      g = -1;
      for (int i = N - 1; i >= 0; i--) if (m_wait[i]) g = i;
      e_pv = (g >= 0); e_cpu = 0; e_vec = 0;
      if (g >= 0) begin e_cpu = m_cpu[g]; e_vec = m_vec[g]; m_wait[g] = 0; end
      w = int'(addr) >> 3;
      e_rdata = 0;
      e_err = req && (w >= 2 * N);
      if (req && !we) begin
        if (w < N) e_rdata = 64'(m_cpu[w] << 8 | m_vec[w]);
        else if (w < 2 * N) e_rdata = 64'({m_mask[w-N], 2'b00} | {2'b00, m_pend[w-N]});
      end
      for (int i = 0; i < N; i++) acc[i] = irq[i] && !m_mask[i];
      if (req && we) begin
        if (w < N) begin m_cpu[w] = int'(wdata[12:8]); m_vec[w] = int'(wdata[5:0]); end
        else if (w < 2 * N) begin
          m_mask[w-N] = wdata[2];
          if (wdata[1]) m_pend[w-N] = 0;
        end
      end
      for (int i = 0; i < N; i++) if (acc[i]) begin
        m_mask[i] = 1; m_pend[i] = 1; m_wait[i] = 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    check(pv == e_pv, "R7 R8 post_valid", longint'(pv), longint'(e_pv));
    check(pcpu == 5'(e_cpu) && pvec == 6'(e_vec), "R7 R8 post cpu/vec",
          longint'({pcpu, pvec}), longint'({5'(e_cpu), 6'(e_vec)}));
    check(rdata == e_rdata, "R12 R1 R2 rdata", longint'(rdata), longint'(e_rdata));
    check(err == e_err, "R10 err", longint'(err), longint'(e_err));
  end

  task automatic wr(input int a, input logic [63:0] d);
    @(negedge clk); req = 1; we = 1; addr = AW'(a); wdata = d;
    @(negedge clk); req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [63:0] d, output logic e);
    @(negedge clk); req = 1; we = 0; addr = AW'(a);
    @(negedge clk); req = 0; d = rdata; e = err;
  endtask

  task automatic fire(input logic [N-1:0] v);
    @(negedge clk); irq = v;
    @(negedge clk); irq = '0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic        e;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_en = 1;
    // R4 reset state
    check(pv == 0, "R4 no post after reset", longint'(pv), 0);
    rd(CTL + 0, d, e);  check(d == 64'h4, "R4 ctl reset", longint'(d), 4);
    rd(0, d, e);        check(d == 0, "R4 route reset", longint'(d), 0);
    // R1 routing layout, junk bits dropped
    wr(3 * 8, 64'hFFFF_0000_0000_E0EA | 64'h152A);
    rd(3 * 8, d, e);    check(d == 64'h152A, "R1 route readback", longint'(d), 64'h152A);
    // R11 low offset bits ignored
    wr(3 * 8 + 3, 64'h0000_0000_0000_0B11);
    rd(3 * 8 + 5, d, e); check(d == 64'h0B11, "R11 low bits ignored", longint'(d), 64'h0B11);
    wr(3 * 8, 64'h152A);
    // R3 bit0 cannot set pending; bit2=0 unmasks
    wr(CTL + 3 * 8, 64'h1);
    rd(CTL + 3 * 8, d, e); check(d == 64'h0, "R3 write cannot set pend", longint'(d), 0);
    // R7 post
    fire(N'(1) << 3);
    @(negedge clk);
    check(pv == 1 && pcpu == 5'h15 && pvec == 6'h2A, "R7 post content",
          longint'({pv, pcpu, pvec}), longint'({1'b1, 5'h15, 6'h2A}));
    @(negedge clk);
    check(pv == 0, "R7 single cycle", longint'(pv), 0);
    // R6 mask and pending set
    rd(CTL + 3 * 8, d, e); check(d == 64'h5, "R6 accept arms", longint'(d), 5);
    // R5 masked drop
    fire(N'(1) << 3);
    repeat (2) begin
      @(negedge clk); check(pv == 0, "R5 masked no post", longint'(pv), 0);
    end
    rd(CTL + 3 * 8, d, e); check(d == 64'h5, "R5 state unchanged", longint'(d), 5);
    // R3 clear pending with bit1, keep mask
    wr(CTL + 3 * 8, 64'h6);
    rd(CTL + 3 * 8, d, e); check(d == 64'h4, "R3 pend clear", longint'(d), 4);
    // R8 ordering
    wr(1 * 8, 64'h0101);
    wr(7 * 8, 64'h0707);
    wr(CTL + 1 * 8, 64'h0);
    wr(CTL + 7 * 8, 64'h0);
    fire((N'(1) << 7) | (N'(1) << 1));
    @(negedge clk);
    check(pv && pcpu == 5'd1 && pvec == 6'd1, "R8 lowest first", longint'({pcpu, pvec}), longint'({5'd1, 6'd1}));
    @(negedge clk);
    check(pv && pcpu == 5'd7 && pvec == 6'd7, "R8 next source", longint'({pcpu, pvec}), longint'({5'd7, 6'd7}));
    // R9 accept and control write to same source in one cycle
    wr(CTL + 1 * 8, 64'h2);
    @(negedge clk); irq = N'(1) << 1; req = 1; we = 1; addr = AW'(CTL + 8); wdata = 64'h2;
    @(negedge clk); irq = '0; req = 0; we = 0; wdata = '0;
    @(negedge clk);
    check(pv == 1 && pcpu == 5'd1, "R9 post still issued", longint'(pv), 1);
    rd(CTL + 1 * 8, d, e); check(d == 64'h5, "R9 interrupt wins", longint'(d), 5);
    // R10 undecoded offsets
    rd(2 * CTL, d, e);
    check(d == 0 && e == 1, "R10 undecoded read", longint'({d[0], e}), 1);
    wr(2 * CTL + 8, 64'hFFFF);
    rd(CTL + 0, d, e); check(d == 64'h4 && e == 0, "R10 write no effect", longint'(d), 4);
    // R12 idle rdata
    @(negedge clk); check(rdata == 0, "R12 idle zero", longint'(rdata), 0);
    // random mix
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      irq = N'($urandom & $urandom & $urandom);
      req = ($urandom % 2) == 0;
      we = $urandom % 2;
      addr = AW'($urandom % (2 * CTL + 64));
      wdata = {$urandom, $urandom} & 64'h0000_0000_0000_1F3F;
      if (($urandom % 4) != 0) wdata[2] = 1'b0;
    end
    @(negedge clk); irq = '0; req = 0; we = 0;
    repeat (N + 4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule